// File: doc/BRIEF.md
# Branch Target Buffer with Hysteresis

This block is a direct-mapped branch target buffer that the fetch stage consults with its current fetch address. In the same cycle it reports whether the address matches a remembered branch. On a match it also reports the remembered direction (taken or not taken) and the remembered target address. When a branch resolves later in the pipeline, its address, actual direction and actual target are presented on an update port. The buffer then allocates, reinforces or corrects the matching entry at the next clock edge.

Each entry keeps a valid bit, an address tag, a target, a direction bit and a confidence state. The confidence state does not count taken versus not taken. It counts how many recent predictions were right, and it stops at two. It has three states: CONF_NONE, CONF_ONE and CONF_FULL. An update that hits the entry performs one of four named transitions:

- bump (correct prediction): CONF_NONE to CONF_ONE, CONF_ONE to CONF_FULL, CONF_FULL stays.
- decay (wrong prediction while confidence is nonzero): CONF_FULL to CONF_ONE, CONF_ONE to CONF_NONE. The prediction is kept.
- replace (wrong prediction at CONF_NONE): the observed direction and target are stored, and the state stays CONF_NONE.
- alloc (an update that misses): the entry is overwritten with the new tag and the observed outcome, and the state is set to CONF_NONE.

A single occasional deviation therefore never flips a well-established prediction. A lasting change in behaviour takes over after a short delay. A synchronous flush input empties the whole table.

Top module: `hyst_btb`

## Requirements
- R1: After reset every lookup misses. On a miss, pred_taken_o is 0 and pred_target_o is 0.
- R2: With default parameters the entry index is address bits [11:3] (512 entries) and the tag is bits [31:12]. Address bits [2:0] never affect a lookup or an update.
- R3: A lookup hits only when the indexed entry is valid and its stored tag equals the tag bits of fetch_pc_i. Another address that shares the index but has a different tag misses.
- R4: An update whose address misses (an invalid entry, or a tag conflict) allocates the entry. The entry takes the new tag, the observed direction and target, and CONF_NONE. The newest branch evicts the older one.
- R5: An update is correct when the observed direction equals the stored direction and, for a taken outcome, the observed target also equals the stored target. A not-taken outcome compares direction only. A correct update leaves the prediction unchanged and bumps confidence, which saturates at CONF_FULL (value 2) and never holds value 3.
- R6: A wrong update at CONF_ONE or CONF_FULL lowers the confidence by one step and keeps the stored direction and target.
- R7: A wrong update at CONF_NONE writes the observed direction and target into the entry, and the entry stays at CONF_NONE.
- R8: Lookup is combinational on fetch_pc_i. An update becomes visible after the next rising clock edge, and a lookup of the same entry in the update cycle returns the old contents.
- R9: flush_i, sampled at a rising edge, invalidates every entry. An update presented in the same cycle as flush_i is dropped.
- R10: While upd_valid_i is low, the upd_* inputs have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous invalidate of all entries |
| fetch_pc_i | input | 32 | Fetch address to look up |
| hit_o | output | 1 | Lookup matched a valid entry |
| pred_taken_o | output | 1 | Predicted direction (0 on miss) |
| pred_target_o | output | 32 | Stored target (0 on miss) |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |

## Verification
The assertions watch the rules every cycle:

- An update is visible at its address in the following cycle.
- A correct update, or a decay, keeps the prediction.
- A replace installs the observed outcome.
- Flush leaves nothing hitting.
- The outputs hold steady when there is no update.
- The stored confidence never takes its unused encoding.

Only the bench scenarios can show the exact number of wrong updates needed to flip a saturated entry, the eviction of an older branch by a conflicting one, the irrelevance of the low address bits, and the old value returned by a lookup in the update cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Confidence: number of recent correct predictions, saturating at two.
    typedef enum logic [1:0] {
        CONF_NONE = 2'd0,
        CONF_ONE  = 2'd1,
        CONF_FULL = 2'd2
    } conf_e;

    // Action chosen for one update.
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_ALLOC   = 3'd1,
        ACT_BUMP    = 3'd2,
        ACT_DECAY   = 3'd3,
        ACT_REPLACE = 3'd4
    } act_e;

endpackage

// File: rtl/btb_conf_fsm.sv
module btb_conf_fsm
    import btb_pkg::*;
(
    input  logic  req_i,
    input  logic  hit_i,
    input  logic  correct_i,
    input  conf_e cur_i,
    output conf_e nxt_o,
    output act_e  act_o
);

    // Next-state and action decode for the per-entry confidence machine.
    always_comb begin
        nxt_o = cur_i;
        act_o = ACT_IDLE;
        if (!req_i) begin
            nxt_o = cur_i;
            act_o = ACT_IDLE;
        end else if (!hit_i) begin
            nxt_o = CONF_NONE;
            act_o = ACT_ALLOC;
        end else begin
            unique case (cur_i)
                CONF_NONE: begin
                    nxt_o = correct_i ? CONF_ONE : CONF_NONE;
                    act_o = correct_i ? ACT_BUMP : ACT_REPLACE;
                end
                CONF_ONE: begin
                    nxt_o = correct_i ? CONF_FULL : CONF_NONE;
                    act_o = correct_i ? ACT_BUMP : ACT_DECAY;
                end
                CONF_FULL: begin
                    nxt_o = correct_i ? CONF_FULL : CONF_ONE;
                    act_o = correct_i ? ACT_BUMP : ACT_DECAY;
                end
                default: begin
                    nxt_o = CONF_NONE;
                    act_o = ACT_ALLOC;
                end
            endcase
        end
    end

endmodule

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
    parameter int TAG_W = 20
) (
    input  logic             valid_i,
    input  logic [TAG_W-1:0] stored_tag_i,
    input  logic [TAG_W-1:0] probe_tag_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = valid_i && (stored_tag_i == probe_tag_i);
    end

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
    import btb_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int TAG_W = 20,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    // write port
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [TAG_W-1:0] wtag_i,
    input  logic [TGT_W-1:0] wtgt_i,
    input  logic             wtkn_i,
    input  conf_e            wconf_i,
    // read port A (fetch)
    input  logic [IDX_W-1:0] ridx_a_i,
    output logic             a_vld_o,
    output logic [TAG_W-1:0] a_tag_o,
    output logic [TGT_W-1:0] a_tgt_o,
    output logic             a_tkn_o,
    output conf_e            a_conf_o,
    // read port B (update)
    input  logic [IDX_W-1:0] ridx_b_i,
    output logic             b_vld_o,
    output logic [TAG_W-1:0] b_tag_o,
    output logic [TGT_W-1:0] b_tgt_o,
    output logic             b_tkn_o,
    output conf_e            b_conf_o
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [TGT_W-1:0] tgt_q  [DEPTH];
    logic             tkn_q  [DEPTH];
    conf_e            conf_q [DEPTH];

    // Valid bits carry the reset and the flush; the payload needs neither.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush_i) begin
            vld_q <= '0;
        end else if (we_i) begin
            vld_q[widx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && !flush_i) begin
            tag_q[widx_i]  <= wtag_i;
            tgt_q[widx_i]  <= wtgt_i;
            tkn_q[widx_i]  <= wtkn_i;
            conf_q[widx_i] <= wconf_i;
        end
    end

    always_comb begin
        a_vld_o  = vld_q[ridx_a_i];
        a_tag_o  = tag_q[ridx_a_i];
        a_tgt_o  = tgt_q[ridx_a_i];
        a_tkn_o  = tkn_q[ridx_a_i];
        a_conf_o = conf_q[ridx_a_i];
        b_vld_o  = vld_q[ridx_b_i];
        b_tag_o  = tag_q[ridx_b_i];
        b_tgt_o  = tgt_q[ridx_b_i];
        b_tkn_o  = tkn_q[ridx_b_i];
        b_conf_o = conf_q[ridx_b_i];
    end

endmodule

// File: rtl/hyst_btb.sv
module hyst_btb
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_LO = 3,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic              hit_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_target_o,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i
);

    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    // Address split
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             unused_low;

    assign f_idx      = fetch_pc_i[TAG_LO-1:IDX_LO];
    assign f_tag      = fetch_pc_i[ADDR_W-1:TAG_LO];
    assign u_idx      = upd_pc_i[TAG_LO-1:IDX_LO];
    assign u_tag      = upd_pc_i[ADDR_W-1:TAG_LO];
    assign unused_low = ^{fetch_pc_i[IDX_LO-1:0], upd_pc_i[IDX_LO-1:0]};

    // Array read data
    logic              f_vld, u_vld;
    logic [TAG_W-1:0]  f_stag, u_stag;
    logic [ADDR_W-1:0] f_tgt, u_tgt;
    logic              f_tkn, u_tkn;
    conf_e             f_conf, u_conf;

    // Write side
    logic              upd_req;
    logic              we;
    logic              u_hit, f_hit;
    logic              upd_correct;
    conf_e             nxt_conf;
    act_e              act;
    logic              wtkn;
    logic [ADDR_W-1:0] wtgt;

    assign upd_req = upd_valid_i && !flush_i;

    btb_tag_match #(.TAG_W(TAG_W)) u_fetch_match (
        .valid_i      (f_vld),
        .stored_tag_i (f_stag),
        .probe_tag_i  (f_tag),
        .hit_o        (f_hit)
    );

    btb_tag_match #(.TAG_W(TAG_W)) u_upd_match (
        .valid_i      (u_vld),
        .stored_tag_i (u_stag),
        .probe_tag_i  (u_tag),
        .hit_o        (u_hit)
    );

    // A not-taken outcome is judged on direction alone.
    always_comb begin
        upd_correct = (u_tkn == upd_taken_i) &&
                      (!upd_taken_i || (u_tgt == upd_target_i));
    end

    btb_conf_fsm u_fsm (
        .req_i     (upd_req),
        .hit_i     (u_hit),
        .correct_i (upd_correct),
        .cur_i     (u_conf),
        .nxt_o     (nxt_conf),
        .act_o     (act)
    );

    always_comb begin
        we = (act != ACT_IDLE);
        unique case (act)
            ACT_ALLOC, ACT_REPLACE: begin
                wtkn = upd_taken_i;
                wtgt = upd_target_i;
            end
            default: begin
                wtkn = u_tkn;
                wtgt = u_tgt;
            end
        endcase
    end

    btb_entry_array #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .TGT_W (ADDR_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .we_i     (we),
        .widx_i   (u_idx),
        .wtag_i   (u_tag),
        .wtgt_i   (wtgt),
        .wtkn_i   (wtkn),
        .wconf_i  (nxt_conf),
        .ridx_a_i (f_idx),
        .a_vld_o  (f_vld),
        .a_tag_o  (f_stag),
        .a_tgt_o  (f_tgt),
        .a_tkn_o  (f_tkn),
        .a_conf_o (f_conf),
        .ridx_b_i (u_idx),
        .b_vld_o  (u_vld),
        .b_tag_o  (u_stag),
        .b_tgt_o  (u_tgt),
        .b_tkn_o  (u_tkn),
        .b_conf_o (u_conf)
    );

    // Lookup outputs
    always_comb begin
        hit_o         = f_hit;
        pred_taken_o  = f_hit && f_tkn;
        pred_target_o = f_hit ? f_tgt : '0;
    end

    // ---------------- assertions ----------------
    logic same_line;
    assign same_line = 1'b1;

    // R9: nothing hits in the cycle after a flush
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !hit_o);

    // R4 / R8: an accepted update is visible at its address in the next cycle
    a_r4_update_visible: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> ((fetch_pc_i[ADDR_W-1:IDX_LO] != $past(upd_pc_i[ADDR_W-1:IDX_LO])) || hit_o));

    // R5: a correct update keeps the predicted direction
    a_r5_correct_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && u_hit && upd_correct) |=>
        ((fetch_pc_i[ADDR_W-1:IDX_LO] != $past(upd_pc_i[ADDR_W-1:IDX_LO])) ||
         (pred_taken_o == $past(upd_taken_i))));

    // R5: stored confidence never holds the unused code 3
    a_r5_conf_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (u_vld && same_line) |-> (u_conf inside {CONF_NONE, CONF_ONE, CONF_FULL}));

    // R6: a decay keeps direction and target
    a_r6_decay_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && u_hit && !upd_correct && (u_conf != CONF_NONE)) |=>
        ((fetch_pc_i[ADDR_W-1:IDX_LO] != $past(upd_pc_i[ADDR_W-1:IDX_LO])) ||
         ((pred_taken_o == $past(u_tkn)) && (pred_target_o == $past(u_tgt)))));

    // R7: a replace installs the observed outcome
    a_r7_replace_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && u_hit && !upd_correct && (u_conf == CONF_NONE)) |=>
        ((fetch_pc_i[ADDR_W-1:IDX_LO] != $past(upd_pc_i[ADDR_W-1:IDX_LO])) ||
         ((pred_taken_o == $past(upd_taken_i)) && (pred_target_o == $past(upd_target_i)))));

    // R10: without update or flush, a held lookup gives held results
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid_i && !flush_i) |=>
        (($past(fetch_pc_i) != fetch_pc_i) ||
         ($stable(hit_o) && $stable(pred_taken_o) && $stable(pred_target_o))));

endmodule

// File: tb/hyst_btb_tb.sv
module hyst_btb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        hit_o;
    logic        pred_taken_o;
    logic [31:0] pred_target_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [31:0] upd_target_i = '0;

    always #4 clk = ~clk;   // 125 MHz

    hyst_btb u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .fetch_pc_i    (fetch_pc_i),
        .hit_o         (hit_o),
        .pred_taken_o  (pred_taken_o),
        .pred_target_o (pred_target_o),
        .upd_valid_i   (upd_valid_i),
        .upd_pc_i      (upd_pc_i),
        .upd_taken_i   (upd_taken_i),
        .upd_target_i  (upd_target_i)
    );

    // Reference model built from the requirements
    bit          m_v   [512];
    int unsigned m_tag [512];
    logic [31:0] m_tgt [512];
    bit          m_tkn [512];
    int          m_cnt [512];

    // Scoreboard queues
    logic        q_hit [$];
    logic        q_tkn [$];
    logic [31:0] q_tgt [$];
    string       q_req [$];

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 1'b0;

    function automatic int idx_of(input logic [31:0] pc);
        return int'(pc[11:3]);
    endfunction

    function automatic void model_expect(input logic [31:0] pc, input string req);
        int i;
        bit h;
        i = idx_of(pc);
        h = m_v[i] && (m_tag[i] == int'(pc[31:12]));
        q_hit.push_back(h);
        q_tkn.push_back(h ? m_tkn[i] : 1'b0);
        q_tgt.push_back(h ? m_tgt[i] : 32'h0);
        q_req.push_back(req);
    endfunction

    function automatic void model_update(input logic [31:0] pc, input bit tk, input logic [31:0] tg);
        int i;
        bit ok;
        i = idx_of(pc);
        if (!(m_v[i] && (m_tag[i] == int'(pc[31:12])))) begin
            m_v[i] = 1'b1; m_tag[i] = int'(pc[31:12]);
            m_tkn[i] = tk; m_tgt[i] = tg; m_cnt[i] = 0;
        end else begin
            ok = (m_tkn[i] == tk) && (!tk || (m_tgt[i] == tg));
            if (ok) begin
                if (m_cnt[i] < 2) m_cnt[i]++;
            end else if (m_cnt[i] > 0) begin
                m_cnt[i]--;
            end else begin
                m_tkn[i] = tk; m_tgt[i] = tg;
            end
        end
    endfunction

    // Monitor: pops one expectation per cycle and compares
    always @(negedge clk) begin
        if (q_hit.size() != 0 && !finished) begin
            logic        eh, et;
            logic [31:0] eg;
            string       r;
            eh = q_hit.pop_front();
            et = q_tkn.pop_front();
            eg = q_tgt.pop_front();
            r  = q_req.pop_front();
            vectors++;
            if (hit_o !== eh || pred_taken_o !== et || pred_target_o !== eg) begin
                miscompares++;
                $display("FAIL %s: got hit=%0b tkn=%0b tgt=%h, expected hit=%0b tkn=%0b tgt=%h",
                         r, hit_o, pred_taken_o, pred_target_o, eh, et, eg);
            end
        end
    end

    // Driver tasks
    task automatic lookup(input logic [31:0] pc, input string req);
        @(posedge clk); #1;
        fetch_pc_i = pc;
        model_expect(pc, req);
    endtask

    task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tg);
        @(posedge clk); #1;
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
        @(posedge clk);
        model_update(pc, tk, tg);
        #1 upd_valid_i = 1'b0;
    endtask

    // Lookup and update the same entry in one cycle
    task automatic lookup_during_update(input logic [31:0] pc, input bit tk,
                                        input logic [31:0] tg, input string req);
        @(posedge clk); #1;
        fetch_pc_i = pc;
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
        model_expect(pc, req);
        @(posedge clk);
        model_update(pc, tk, tg);
        #1 upd_valid_i = 1'b0;
    endtask

    task automatic flush_with_update(input logic [31:0] pc);
        @(posedge clk); #1;
        flush_i = 1'b1;
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = 1'b1; upd_target_i = 32'hABCD_0000;
        @(posedge clk);
        for (int i = 0; i < 512; i++) m_v[i] = 1'b0;
        #1 flush_i = 1'b0; upd_valid_i = 1'b0;
    endtask

    task automatic drain();
        while (q_hit.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [31:0] PA = 32'h0000_2048;   // index 9, tag 2
    localparam logic [31:0] PB = 32'h0000_3048;   // index 9, tag 3

    initial begin
        for (int i = 0; i < 512; i++) begin
            m_v[i] = 1'b0; m_tag[i] = 0; m_tgt[i] = '0; m_tkn[i] = 1'b0; m_cnt[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        lookup(PA, "R1");
        lookup(32'hFFFF_FFF8, "R1");

        // R4: allocation on miss
        update(PA, 1'b1, 32'h0000_4000);
        lookup(PA, "R4");
        // R7: wrong at CONF_NONE replaces the prediction
        update(PA, 1'b0, 32'h0000_5000);
        lookup(PA, "R7");
        // R5: not-taken compares direction only; three correct updates saturate
        update(PA, 1'b0, 32'h0000_6666);
        lookup(PA, "R5");
        update(PA, 1'b0, 32'h0000_5000);
        update(PA, 1'b0, 32'h0000_5000);
        lookup(PA, "R5");
        // R6: two wrong updates from saturation only decay
        update(PA, 1'b1, 32'h0000_7000);
        lookup(PA, "R6");
        update(PA, 1'b1, 32'h0000_7000);
        lookup(PA, "R6");
        // R7: third wrong update flips
        update(PA, 1'b1, 32'h0000_7000);
        lookup(PA, "R7");
        // R5/R7: a taken outcome with a different target is wrong
        update(PA, 1'b1, 32'h0000_7100);
        lookup(PA, "R7");

        // R3: same index, other tag misses
        lookup(PB, "R3");
        // R4: conflict evicts the older branch
        update(PB, 1'b1, 32'h0000_9000);
        lookup(PB, "R4");
        lookup(PA, "R4");
        // R2: low bits ignored; neighbouring index separate
        lookup(PB + 32'd5, "R2");
        lookup(PB + 32'd8, "R2");
        update(32'hFFFF_FFFA, 1'b1, 32'h1234_5678);
        lookup(32'hFFFF_FFF8, "R2");

        // R10: update fields with strobe low change nothing
        @(posedge clk); #1;
        upd_pc_i = PB; upd_taken_i = 1'b0; upd_target_i = 32'h0;
        repeat (2) @(posedge clk);
        lookup(PB, "R10");

        // R8: same-cycle lookup sees old contents, next cycle sees new
        lookup_during_update(PB, 1'b0, 32'h0000_AAAA, "R8");
        lookup(PB, "R8");

        // R9: flush empties table and drops concurrent update
        flush_with_update(32'h0000_0300);
        lookup(PB, "R9");
        lookup(32'h0000_0300, "R9");
        lookup(32'hFFFF_FFF8, "R9");

        drain();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule